// File: doc/BRIEF.md
# Saturating 3x3 Dot-Product Datapath

This block is the arithmetic core of a convolution engine. In every cycle it can accept one 3x3 window: nine signed 8-bit feature samples, the nine matching signed 8-bit kernel coefficients, and a signed 32-bit offset. It multiplies each feature by its coefficient and reduces the nine products through a registered adder tree. Each level of the tree is one bit wider than the level below it. The offset is then added at 33 bits, and the sum is clamped to a symmetric 32-bit range. The clamped value goes to a downstream accumulation path.

The block is fully pipelined. A new window may arrive on every cycle, and a flag travels alongside the data to mark which output cycles carry results. The clamp never produces the most negative 32-bit code. The output range is therefore symmetric about zero, and a later negation or sign-magnitude step cannot overflow.

Top module: `conv3_sat_dot`

## Requirements
- R1: `res_valid` rises exactly 7 cycles (with the default parameters) after the clock edge that samples `win_valid` high. One result is produced for every accepted window, including windows on back-to-back cycles, and the results keep their input order.
- R2: When the exact sum of the nine products plus the offset lies within [-(2^31-1), 2^31-1], `res_data` equals that sum as a 32-bit two's-complement value. Inputs are symmetrically quantized, so every feature and coefficient lies in [-127, 127].
- R3: A sum above 2^31-1 is reported as 0x7FFFFFFF. A sum of exactly 2^31-1 passes through unchanged.
- R4: A sum below -2^31 is reported as 0x80000001. A sum of exactly -(2^31-1) passes through as 0x80000001.
- R5: A sum of exactly -2^31 is reported as 0x80000001. While `res_valid` is high, `res_data` never equals 0x80000000.
- R6: While `rst_n` is low, `res_valid` is 0 and `res_data` is 0.
- R7: Tap i, for i from 0 to 8, occupies bits [8i+7:8i] of both `win_feat` and `win_coef`. A feature is multiplied only by the coefficient in the same tap position.
- R8: The product width is twice the sample width, and each adder level adds one bit. With all nine products at -127 x 127 (sum -145161) or 127 x 127 (sum +145161), the result is exact.
- R9: Cycles with `win_valid` low produce no result, whatever values the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | 1 | The window on the data inputs is to be processed |
| win_feat | input | 72 | Nine signed 8-bit features, tap i at bits [8i+7:8i] |
| win_coef | input | 72 | Nine signed 8-bit coefficients, same tap layout |
| win_bias | input | 32 | Signed offset added to the dot product |
| res_valid | output | 1 | `res_data` holds a result |
| res_data | output | 32 | Clamped signed result |

## Verification
The bench builds the block with its default parameters: nine taps, 8-bit samples and a 32-bit offset. Because the offset spans the full 32-bit range, every saturation branch can be reached, including the exact -2^31 sum and both pass-through edges, simply by placing the offset next to a limit and adding a small product sum. The extreme all-(-127 x 127) and all-(127 x 127) windows drive the widest tree level to its largest magnitude. Random windows arrive back to back with bubbles, and the junk driven during bubbles tests that idle cycles yield no results.

// File: rtl/conv3_pkg.sv
package conv3_pkg;

  // Outcome of the range test on the widened sum
  typedef enum logic [1:0] {
    SAT_PASS = 2'd0,
    SAT_HIGH = 2'd1,
    SAT_LOW  = 2'd2,
    SAT_EDGE = 2'd3
  } sat_kind_e;

  // Decide the clamp action from the two top bits of the widened sum
  // and whether the low word is the most negative code.
  function automatic sat_kind_e sat_classify(input logic top_bit,
                                             input logic next_bit,
                                             input logic low_is_min);
    sat_kind_e k;
    case ({top_bit, next_bit})
      2'b00:   k = SAT_PASS;
      2'b01:   k = SAT_HIGH;
      2'b10:   k = SAT_LOW;
      default: k = low_is_min ? SAT_EDGE : SAT_PASS;
    endcase
    return k;
  endfunction

  // Number of nodes at a given level of a pairwise reduction tree
  function automatic int level_nodes(input int leaves, input int lvl);
    return (leaves + (1 << lvl) - 1) >> lvl;
  endfunction

endpackage

// File: rtl/conv3_mul.sv
module conv3_mul #(
  parameter int TAPS = 9,
  parameter int IN_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       v_in,
  input  logic [TAPS*IN_W-1:0]       feat_bus,
  input  logic [TAPS*IN_W-1:0]       coef_bus,
  output logic                       v_out,
  output logic [TAPS*2*IN_W-1:0]     prod_bus
);
  localparam int PW       = 2 * IN_W;
  localparam int SAMP_MAX = (1 << (IN_W - 1)) - 1;
  localparam int PROD_MAX = SAMP_MAX * SAMP_MAX;
  localparam logic [IN_W-1:0] SAMP_FORBID = {1'b1, {(IN_W-1){1'b0}}};

  function automatic logic signed [PW-1:0] tap_mul(input logic signed [IN_W-1:0] a,
                                                   input logic signed [IN_W-1:0] b);
    logic signed [PW-1:0] r;
    r = a * b;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_bus <= '0;
      v_out    <= 1'b0;
    end else begin
      v_out <= v_in;
      for (int t = 0; t < TAPS; t++) begin
        prod_bus[t*PW +: PW] <= tap_mul(feat_bus[t*IN_W +: IN_W], coef_bus[t*IN_W +: IN_W]);
      end
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_chk
    logic signed [PW-1:0] prod_t;
    assign prod_t = prod_bus[t*PW +: PW];

    AST_FEAT_SYMM: assert property (@(posedge clk) disable iff (!rst_n)
      v_in |-> (feat_bus[t*IN_W +: IN_W] != SAMP_FORBID)
               && (coef_bus[t*IN_W +: IN_W] != SAMP_FORBID)); // R2

    AST_PROD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      v_out |-> (prod_t <= PW'(PROD_MAX)) && (prod_t >= -PW'(PROD_MAX))); // R8
  end

endmodule

// File: rtl/conv3_tree.sv
module conv3_tree
  import conv3_pkg::*;
#(
  parameter int TAPS = 9,
  parameter int PW   = 16,
  parameter int SW   = PW + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_in,
  input  logic [TAPS*PW-1:0] prod_bus,
  output logic              v_out,
  output logic [SW-1:0]     sum
);
  localparam int LVLS     = $clog2(TAPS);
  localparam int PROD_MAX = ((1 << (PW/2 - 1)) - 1) * ((1 << (PW/2 - 1)) - 1);
  localparam int SUM_MAX  = TAPS * PROD_MAX;

  logic signed [PW-1:0] lv0  [TAPS];
  logic signed [SW-1:0] node [LVLS+1][TAPS];
  logic [LVLS-1:0]      vq;

  always_comb begin
    for (int j = 0; j < TAPS; j++) lv0[j] = prod_bus[j*PW +: PW];
  end

  for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
    localparam int CNT = level_nodes(TAPS, l);
    localparam int PRV = level_nodes(TAPS, l - 1);
    localparam int LW  = PW + l;

    logic signed [LW-2:0] src  [TAPS];
    logic signed [LW-1:0] part [TAPS];

    if (l == 1) begin : g_first
      always_comb begin
        for (int j = 0; j < TAPS; j++) src[j] = lv0[j][LW-2:0];
      end
    end else begin : g_next
      always_comb begin
        for (int j = 0; j < TAPS; j++) src[j] = node[l-1][j][LW-2:0];
      end
    end

    // pairwise add in a width one bit above the inputs
    always_comb begin
      for (int j = 0; j < TAPS; j++) begin
        if (j >= CNT)
          part[j] = '0;
        else if (2*j + 1 < PRV)
          part[j] = LW'(src[2*j]) + LW'(src[2*j+1]);
        else
          part[j] = LW'(src[2*j]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int j = 0; j < TAPS; j++) node[l][j] <= '0;
      end else begin
        for (int j = 0; j < TAPS; j++) node[l][j] <= SW'(part[j]);
      end
    end
  end

  // level 0 of the node array is not used; hold it at zero
  always_comb begin
    for (int j = 0; j < TAPS; j++) node[0][j] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vq <= '0;
    else        vq <= (vq << 1) | LVLS'(v_in);
  end

  assign v_out = vq[LVLS-1];
  assign sum   = node[LVLS][0];

  AST_TREE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    v_out |-> ($signed(sum) <= SW'(SUM_MAX)) && ($signed(sum) >= -SW'(SUM_MAX))); // R8

endmodule

// File: rtl/conv3_sat.sv
module conv3_sat
  import conv3_pkg::*;
#(
  parameter int SUM_W = 20,
  parameter int B_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  input  logic [SUM_W-1:0] sum,
  input  logic [B_W-1:0]   bias,
  output logic             v_out,
  output logic [B_W-1:0]   result
);
  localparam int WW = B_W + 1;
  localparam logic [B_W-1:0] MOST_POS = {1'b0, {(B_W-1){1'b1}}};
  localparam logic [B_W-1:0] MOST_NEG = {1'b1, {(B_W-1){1'b0}}};
  localparam logic [B_W-1:0] SYM_NEG  = MOST_NEG | B_W'(1);

  function automatic logic [B_W-1:0] clamp_pick(input sat_kind_e k, input logic [B_W-1:0] low);
    logic [B_W-1:0] r;
    case (k)
      SAT_HIGH: r = MOST_POS;
      SAT_LOW:  r = SYM_NEG;
      SAT_EDGE: r = SYM_NEG;
      default:  r = low;
    endcase
    return r;
  endfunction

  logic signed [WW-1:0] wide_q;
  logic                 va;
  sat_kind_e            cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= '0;
      va     <= 1'b0;
    end else begin
      wide_q <= WW'(signed'(sum)) + WW'(signed'(bias));
      va     <= v_in;
    end
  end

  always_comb cls = sat_classify(wide_q[WW-1], wide_q[WW-2], wide_q[B_W-1:0] == MOST_NEG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      v_out  <= 1'b0;
    end else begin
      result <= clamp_pick(cls, wide_q[B_W-1:0]);
      v_out  <= va;
    end
  end

  AST_HIGH_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (va && cls == SAT_HIGH) |=> (result == MOST_POS)); // R3
  AST_LOW_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (va && cls == SAT_LOW) |=> (result == SYM_NEG)); // R4
  AST_EDGE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (va && cls == SAT_EDGE) |=> (result == SYM_NEG)); // R5
  AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    v_out |-> (result != MOST_NEG)); // R5
  AST_PASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (va && cls == SAT_PASS) |=> (result == $past(wide_q[B_W-1:0]))); // R2

endmodule

// File: rtl/conv3_sat_dot.sv
module conv3_sat_dot #(
  parameter int TAPS = 9,
  parameter int IN_W = 8,
  parameter int B_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_valid,
  input  logic [TAPS*IN_W-1:0] win_feat,
  input  logic [TAPS*IN_W-1:0] win_coef,
  input  logic [B_W-1:0]       win_bias,
  output logic                 res_valid,
  output logic [B_W-1:0]       res_data
);
  localparam int PW   = 2 * IN_W;
  localparam int LVLS = $clog2(TAPS);
  localparam int SW   = PW + LVLS;
  localparam int DLY  = 1 + LVLS;      // multiplier + tree levels
  localparam int LAT  = DLY + 2;       // + offset add + clamp
  localparam int FW   = $clog2(LAT + 2);

  logic                 mul_v, tree_v;
  logic [TAPS*PW-1:0]   prod_bus;
  logic [SW-1:0]        tree_sum;
  logic [B_W-1:0]       bias_pipe [DLY];

  conv3_mul #(.TAPS(TAPS), .IN_W(IN_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .v_in(win_valid),
    .feat_bus(win_feat), .coef_bus(win_coef),
    .v_out(mul_v), .prod_bus(prod_bus)
  );

  conv3_tree #(.TAPS(TAPS), .PW(PW), .SW(SW)) u_tree (
    .clk(clk), .rst_n(rst_n), .v_in(mul_v), .prod_bus(prod_bus),
    .v_out(tree_v), .sum(tree_sum)
  );

  // offset travels beside the products to meet the tree result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DLY; k++) bias_pipe[k] <= '0;
    end else begin
      bias_pipe[0] <= win_bias;
      for (int k = 1; k < DLY; k++) bias_pipe[k] <= bias_pipe[k-1];
    end
  end

  conv3_sat #(.SUM_W(SW), .B_W(B_W)) u_sat (
    .clk(clk), .rst_n(rst_n), .v_in(tree_v), .sum(tree_sum),
    .bias(bias_pipe[DLY-1]), .v_out(res_valid), .result(res_data)
  );

  // windows accepted but not yet delivered
  logic [FW-1:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + FW'(win_valid) - FW'(res_valid);
  end

  AST_FLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= FW'(LAT)); // R1
  AST_OUT_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (inflight != '0)); // R9

endmodule

// File: tb/test_conv3_sat_dot.sv
module test_conv3_sat_dot;
  localparam int TAPS = 9;
  localparam int IW   = 8;
  localparam int BW   = 32;
  localparam int LAT  = 7;
  localparam longint POS_LIM = 64'sd2147483647;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              win_valid = 1'b0;
  logic [TAPS*IW-1:0] win_feat = '0;
  logic [TAPS*IW-1:0] win_coef = '0;
  logic [BW-1:0]     win_bias = '0;
  logic              res_valid;
  logic [BW-1:0]     res_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  logic [BW-1:0] exp_q[$];
  int            stamp_q[$];
  string         tag_q[$];

  conv3_sat_dot #(.TAPS(TAPS), .IN_W(IW), .B_W(BW)) i_conv3_sat_dot (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid),
    .win_feat(win_feat), .win_coef(win_coef), .win_bias(win_bias),
    .res_valid(res_valid), .res_data(res_data)
  );

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference: exact sum in 64-bit integers, then symmetric limit
  function automatic longint exact_sum(input logic [TAPS*IW-1:0] f, input logic [TAPS*IW-1:0] w,
                                       input logic [BW-1:0] b);
    longint s = longint'($signed(b));
    for (int i = 0; i < TAPS; i++)
      s += longint'($signed(f[i*IW +: IW])) * longint'($signed(w[i*IW +: IW]));
    return s;
  endfunction

  function automatic logic [BW-1:0] limit(input longint s);
    if (s > POS_LIM)  return 32'h7FFFFFFF;
    if (s < -POS_LIM) return 32'h80000001;
    return s[BW-1:0];
  endfunction

  function automatic string auto_tag(input longint s);
    if (s > POS_LIM)               return "R3";
    if (s == -POS_LIM - 1)         return "R5";
    if (s < -POS_LIM)              return "R4";
    return "R2";
  endfunction

  task automatic drive(input logic [TAPS*IW-1:0] f, input logic [TAPS*IW-1:0] w,
                       input logic [BW-1:0] b, input string tag);
    longint s;
    @(negedge clk);
    win_feat  = f;
    win_coef  = w;
    win_bias  = b;
    win_valid = 1'b1;
    s = exact_sum(f, w, b);
    exp_q.push_back(limit(s));
    stamp_q.push_back(cyc);
    tag_q.push_back(tag == "" ? auto_tag(s) : tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      win_valid = 1'b0;
      win_feat  = {$urandom, $urandom, $urandom};   // junk, R9
      win_coef  = {$urandom, $urandom, $urandom};
      win_bias  = $urandom;
    end
  endtask

  function automatic logic [TAPS*IW-1:0] fill(input int v);
    logic [TAPS*IW-1:0] r;
    for (int i = 0; i < TAPS; i++) r[i*IW +: IW] = IW'(v);
    return r;
  endfunction

  function automatic logic [TAPS*IW-1:0] rand_win();
    logic [TAPS*IW-1:0] r;
    for (int i = 0; i < TAPS; i++) r[i*IW +: IW] = IW'(int'($urandom_range(254)) - 127);
    return r;
  endfunction

  // monitor: pops the scoreboard as results emerge
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 spurious result", longint'(res_data), 0);
      end else begin
        logic [BW-1:0] e;
        int st;
        string tg;
        e  = exp_q.pop_front();
        st = stamp_q.pop_front();
        tg = tag_q.pop_front();
        check(cyc - st == LAT, "R1 latency", cyc - st, LAT);
        check(res_data == e, tg, longint'(res_data), longint'(e));
        check(res_data != 32'h80000000, "R5 most negative code", longint'(res_data), 32'h80000001);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [TAPS*IW-1:0] ftap, wtap;
    // R6: reset state
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(res_valid == 1'b0, "R6 valid in reset", res_valid, 0);
      check(res_data == '0, "R6 data in reset", res_data, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    drive('0, '0, '0, "R2");
    drive(fill(3), fill(-5), 32'd1000, "R2");
    // R8: extreme products, both signs
    drive(fill(-127), fill(127), '0, "R8");
    drive(fill(127), fill(127), '0, "R8");
    drive(fill(-127), fill(-127), 32'hFFFF0000, "R8");
    // R3: above and exactly at the positive limit
    drive(fill(1), fill(1), 32'h7FFFFFFF, "R3");
    drive('0, '0, 32'h7FFFFFFF, "R3");
    drive(fill(127), fill(127), 32'h7FFE0000, "R3");
    // R5: exactly -2^31
    drive('0, '0, 32'h80000000, "R5");
    ftap = '0; ftap[IW-1:0] = IW'(-1);
    wtap = '0; wtap[IW-1:0] = IW'(1);
    drive(ftap, wtap, 32'h80000001, "R5");
    // R4: below -2^31 and exactly at -(2^31-1)
    drive(fill(-127), fill(127), 32'h80000000, "R4");
    drive('0, '0, 32'h80000001, "R4");
    drive(fill(-1), fill(1), 32'h80000005, "R4");
    idle(3);

    // R7: one coefficient tap alive at a time, features distinct per tap
    for (int k = 0; k < TAPS; k++) begin
      for (int i = 0; i < TAPS; i++) ftap[i*IW +: IW] = IW'(i + 1);
      wtap = '0;
      wtap[k*IW +: IW] = IW'(10 + k);
      drive(ftap, wtap, '0, "R7");
    end
    idle(4);

    // random windows with bubbles and offsets near both limits
    for (int n = 0; n < 400; n++) begin
      logic [BW-1:0] b;
      case ($urandom_range(3))
        0: b = $urandom;
        1: b = 32'h7FFFFFFF - BW'($urandom_range(200000));
        2: b = 32'h80000000 + BW'($urandom_range(200000));
        default: b = BW'(int'($urandom_range(2000)) - 1000);
      endcase
      drive(rand_win(), rand_win(), b, "");
      if ($urandom_range(5) == 0) idle(int'($urandom_range(3)) + 1);
    end
    idle(LAT + 4);

    check(exp_q.size() == 0, "R1 results outstanding", exp_q.size(), 0);
    finish_run();
  end

endmodule